// File: doc/BRIEF.md
# Burst Column Order Generator

This block produces the column address of every data beat inside one burst of a double-data-rate memory access. A requester presents a start column, a burst length selector and an ordering mode, then pulses a start strobe. Starting on the next clock, the block emits one column address per cycle, together with a valid flag and a flag that marks the final beat.

Only the column bits inside the burst window are reordered: two bits for a 4-beat burst and three bits for an 8-beat burst. All bits above the window are copied from the start column on every beat. Two orderings are available. In the first, the window counts up from the start value and wraps. In the second, each beat's window equals the start window XOR the beat number. A new start can be accepted on the final beat, so consecutive bursts follow each other with no gap.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o` and `last_o` are low and stay low until a start is accepted.
- R2: A start accepted at a clock edge makes `valid_o` high for exactly 4 cycles (`len8_i`=0) or 8 cycles (`len8_i`=1), beginning in the cycle after that edge.
- R3: With `ilv_i`=0 and length 4, `col_o[1:0]` on beat k equals (start[1:0] + k) mod 4. For example, start 1 gives 1,2,3,0.
- R4: With `ilv_i`=1, the window bits on beat k equal the start window bits XOR k, for both lengths. For example, start 1 at length 4 gives 1,0,3,2, and start 6 at length 8 gives 6,7,4,5,2,3,0,1.
- R5: With `ilv_i`=0 and length 8, `col_o[2:0]` on beat k equals (start[2:0] + k) mod 8. For example, start 5 gives 5,6,7,0,1,2,3,4.
- R6: At length 4, start bit 2 has no influence on the order of bits [1:0], and `col_o[2]` equals start bit 2 on every beat.
- R7: Column bits above the burst window equal the start column on every beat of the burst.
- R8: `last_o` is high only while `valid_o` is high, on the final beat of the burst and on no other beat.
- R9: A start presented during the final beat is accepted, and the first beat of the new burst appears in the very next cycle.
- R10: A start presented on a beat that is not the final beat is ignored. The running burst continues with its own addresses and length.
- R11: The ordering mode and the length are captured when the start is accepted. Changes on `ilv_i`, `len8_i` or `start_col_i` during a burst do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request strobe |
| start_col_i | input | COL_W | Column at which the burst begins |
| len8_i | input | 1 | Burst length: 0 = 4 beats, 1 = 8 beats |
| ilv_i | input | 1 | Ordering: 0 = wrapping increment, 1 = XOR interleave |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one of the burst |

## Verification
The assertions rely on the captured length and mode staying constant through a burst. They also rely on a start arriving only when the block is idle or on the final beat, if it is to be honoured. A start at any other time must leave the running burst untouched. The stimulus drives all inputs on the falling edge, so every start is seen cleanly at a single rising edge. The stimulus also deliberately places starts and mode changes in the middle of bursts, to exercise the ignore path within those assumptions.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

    localparam int unsigned WIN_MAX = 3;   // window bits for the longest burst

    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;

    function automatic logic [WIN_MAX-1:0] win_mask(input logic len8);
        return len8 ? 3'b111 : 3'b011;
    endfunction

endpackage

// File: rtl/burst_ctl.sv
module burst_ctl
    import burst_col_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [COL_W-1:0]   start_col_i,
    input  logic               len8_i,
    input  logic               ilv_i,
    output logic               active_o,
    output logic               final_o,
    output logic [WIN_MAX-1:0] beat_o,
    output logic [COL_W-1:0]   base_o,
    output logic               len8_o,
    output order_e             order_o
);

    typedef struct packed {
        logic               active;
        logic [WIN_MAX-1:0] beat;
        logic               len8;
        order_e             order;
        logic [COL_W-1:0]   base;
    } ctl_t;

    ctl_t st_d, st_q;
    logic last_beat;
    logic accept;

    always_comb begin
        last_beat = st_q.active && (st_q.beat == (st_q.len8 ? 3'd7 : 3'd3));
        accept    = start_i && (!st_q.active || last_beat);
        st_d      = st_q;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.beat   = '0;
            st_d.len8   = len8_i;
            st_d.order  = order_e'(ilv_i);
            st_d.base   = start_col_i;
        end else if (st_q.active) begin
            if (last_beat) begin
                st_d.active = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, beat: '0, len8: 1'b0, order: ORD_WRAP, base: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign final_o  = last_beat;
    assign beat_o   = st_q.beat;
    assign base_o   = st_q.base;
    assign len8_o   = st_q.len8;
    assign order_o  = st_q.order;

endmodule

// File: rtl/col_order_unit.sv
module col_order_unit
    import burst_col_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0]   base_i,
    input  logic [WIN_MAX-1:0] beat_i,
    input  logic               len8_i,
    input  order_e             order_i,
    output logic [COL_W-1:0]   col_o
);

    logic [WIN_MAX-1:0] mask;
    logic [WIN_MAX-1:0] wrapped;
    logic [WIN_MAX-1:0] xored;
    logic [WIN_MAX-1:0] perm;

    always_comb begin
        mask    = win_mask(len8_i);
        wrapped = base_i[WIN_MAX-1:0] + beat_i;
        xored   = base_i[WIN_MAX-1:0] ^ beat_i;
        perm    = (order_i == ORD_XOR) ? xored : wrapped;
    end

    for (genvar g = 0; g < COL_W; g++) begin : g_bit
        if (g < WIN_MAX) begin : g_win
            assign col_o[g] = mask[g] ? perm[g] : base_i[g];
        end else begin : g_pass
            assign col_o[g] = base_i[g];
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic             len8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    logic               active_q;
    logic               final_q;
    logic [WIN_MAX-1:0] beat_q;
    logic [COL_W-1:0]   base_q;
    logic               len8_q;
    order_e             order_q;

    burst_ctl #(.COL_W(COL_W)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len8_i      (len8_i),
        .ilv_i       (ilv_i),
        .active_o    (active_q),
        .final_o     (final_q),
        .beat_o      (beat_q),
        .base_o      (base_q),
        .len8_o      (len8_q),
        .order_o     (order_q)
    );

    col_order_unit #(.COL_W(COL_W)) ord_i (
        .base_i  (base_q),
        .beat_i  (beat_q),
        .len8_i  (len8_q),
        .order_i (order_q),
        .col_o   (col_o)
    );

    assign valid_o = active_q;
    assign last_o  = final_q;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
    import burst_col_seq_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             len8_q,
    input order_e           order_q
);

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R8

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i) |=> (valid_o && !last_o)); // R2

    AST_END_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o); // R2

    AST_CHAIN_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i) |=> (valid_o && !last_o)); // R9

    AST_MID_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o); // R10

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3])); // R7

    AST_WRAP4_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !len8_q && order_q == ORD_WRAP)
            |=> (col_o[1:0] == $past(col_o[1:0]) + 2'd1) && $stable(col_o[2])); // R3

    AST_WRAP8_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && len8_q && order_q == ORD_WRAP)
            |=> (col_o[2:0] == $past(col_o[2:0]) + 3'd1)); // R5

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .len8_q  (len8_q),
    .order_q (order_q)
);

// File: tb/burst_col_seq_tb_top.sv
`timescale 1ns/1ps
module burst_col_seq_tb_top;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic             len8_i = 1'b0;
    logic             ilv_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    burst_col_seq #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len8_i(len8_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int k, input bit l8, input bit ilv);
        int m = l8 ? 7 : 3;
        int w = ilv ? ((s ^ k) & m) : ((s + k) & m);
        return (s & ~m) | w;
    endfunction

    // Caller is at a negedge; presents a start that the next posedge accepts.
    task automatic launch(input int s, input bit l8, input bit ilv);
        start_i = 1'b1; start_col_i = s[COL_W-1:0]; len8_i = l8; ilv_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Checks each beat at negedge; optionally raises start on beat poke_at.
    task automatic expect_burst(input int s, input bit l8, input bit ilv, input string req,
                                input int poke_at, input int ps, input bit pl8, input bit pilv);
        int n = l8 ? 8 : 4;
        for (int k = 0; k < n; k++) begin
            check(valid_o == 1'b1, {req, " valid"}, valid_o, 1);
            check(col_o == exp_col(s, k, l8, ilv), {req, " col"}, col_o, exp_col(s, k, l8, ilv));
            check(last_o == (k == n - 1), {req, " R8 last"}, last_o, (k == n - 1));
            if (k == poke_at) begin
                start_i = 1'b1; start_col_i = ps[COL_W-1:0]; len8_i = pl8; ilv_i = pilv;
            end
            @(negedge clk);
            if (k == poke_at) start_i = 1'b0;
        end
    endtask

    task automatic expect_idle(input string req);
        check(valid_o == 1'b0, {req, " idle valid"}, valid_o, 0);
        check(last_o == 1'b0, {req, " idle last"}, last_o, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_idle("R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_idle("R1");
    endtask

    task automatic t_wrap4;   // R3 R2
        launch(1, 0, 0);
        expect_burst(1, 0, 0, "R3", -1, 0, 0, 0);
        expect_idle("R2");
        launch(2, 0, 0);
        expect_burst(2, 0, 0, "R3", -1, 0, 0, 0);
        expect_idle("R2");
    endtask

    task automatic t_xor;     // R4
        launch(1, 0, 1);
        expect_burst(1, 0, 1, "R4", -1, 0, 0, 0);
        expect_idle("R4");
        launch(6, 1, 1);
        expect_burst(6, 1, 1, "R4", -1, 0, 0, 0);
        expect_idle("R4");
    endtask

    task automatic t_wrap8;   // R5 R2
        launch(5, 1, 0);
        expect_burst(5, 1, 0, "R5", -1, 0, 0, 0);
        expect_idle("R2");
    endtask

    task automatic t_bit2;    // R6: start 5 at length 4 orders like start 1, bit2 held
        launch(5, 0, 0);
        expect_burst(5, 0, 0, "R6", -1, 0, 0, 0);
        expect_idle("R6");
        launch(7, 0, 1);
        expect_burst(7, 0, 1, "R6", -1, 0, 0, 0);
        expect_idle("R6");
    endtask

    task automatic t_upper;   // R7
        launch('h3A5, 1, 0);
        expect_burst('h3A5, 1, 0, "R7", -1, 0, 0, 0);
        launch('h2DB, 0, 1);
        expect_burst('h2DB, 0, 1, "R7", -1, 0, 0, 0);
        expect_idle("R7");
    endtask

    task automatic t_chain;   // R9
        launch('h103, 0, 0);
        expect_burst('h103, 0, 0, "R9 first", 3, 'h0F6, 1, 1);
        expect_burst('h0F6, 1, 1, "R9 second", 7, 'h012, 0, 1);
        expect_burst('h012, 0, 1, "R9 third", -1, 0, 0, 0);
        expect_idle("R9");
    endtask

    task automatic t_ignore;  // R10 R11: mid-burst start and input changes
        launch('h044, 0, 0);
        expect_burst('h044, 0, 0, "R10", 1, 'h3FF, 1, 1);
        expect_idle("R10");
        launch('h1C2, 1, 1);
        start_col_i = 'h005; len8_i = 1'b0; ilv_i = 1'b0;
        expect_burst('h1C2, 1, 1, "R11", -1, 0, 0, 0);
        expect_idle("R11");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_wrap4();
        t_xor();
        t_wrap8();
        t_bit2();
        t_upper();
        t_chain();
        t_ignore();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule